// File: doc/BRIEF.md
# Nibble-Bus Calendar Clock with Banked Registers

This block keeps wall-clock time and date as packed decimal digits. It advances once for each pulse on a one-hertz input and gives a host access through a narrow register port, with a 4-bit index and a 4-bit data nibble. Each index holds one decimal digit. A control nibble at the top index is visible from every bank. It selects which of the banks the lower fifteen indexes reach: the running time, the alarm setting, or a timer control word that is only stored.

Each one-hertz pulse opens a short busy window, and the digits advance on the last edge of that window. A host that reads the time digits while busy is low gets a coherent snapshot. A stop bit freezes the count so that the host can load a new time without a carry ripping through half-written digits. The alarm compares the seconds, minutes, hours, weekday and day fields against the running time after every advance. Any field can be excluded from the comparison with a don't-care bit. A match raises a sticky flag, and an active-low interrupt line follows that flag while interrupts are enabled.

Top module: `nibble_rtc`

## Requirements
- R1: After synchronous reset the time reads 2000-01-01 00:00:00 with weekday 0, the control nibble reads 0, the alarm control nibble reads 0, and irq_n is high.
- R2: A read (bus_sel=1, bus_we=0) returns the addressed nibble on bus_rdata one clock later, with every bit above bit 3 zero. A write stores only bus_wdata[3:0].
- R3: Index 0xF is the control nibble in every bank. Bit 0 is a read-only busy flag, bit 1 is stop, and bits 3:2 select the bank: 0 time, 1 alarm, 2 timer control, 3 empty.
- R4: A tick pulse taken while stop is clear raises busy for BUSY_CYC clocks. The time digits keep their old values during the window and take the advanced value on the edge where busy falls. Ticks that arrive while busy is high are dropped.
- R5: While stop is set, tick pulses neither raise busy nor change any time digit.
- R6: Time bank indexes 0 to 5 hold the seconds, minutes and hours as unit/tens pairs. Seconds and minutes wrap from 59 to 00 with a carry, and hours wrap from 23 to 00 with a carry.
- R7: Index 6 is the weekday (0 to 6), which wraps from 6 to 0 at midnight. Indexes 7 and 8 are the day units and tens. The day returns to 01 after the last day of the month, which is 30 for April, June, September and November, 31 for the other months except February, and 28 or 29 for February.
- R8: February has 29 days when the four-digit year is divisible by 4, except in century years, which need divisibility by 400.
- R9: Indexes 9 and 10 hold the month (01 to 12), which wraps from 12 to 01 and increments the year. Indexes 11 to 14 hold the year digits from units up to thousands, and 9999 wraps to 0000.
- R10: Alarm bank indexes 0 to 8 mirror the time positions. Bit 3 of alarm indexes 1, 3, 5, 6 and 8 removes that field from the compare. On the first clock after an advance, if every remaining field equals the time, the alarm flag is set.
- R11: Alarm bank index 0xE holds the interrupt enable in bit 0 and the alarm flag in bit 1. Writing bit 1 as 0 clears the flag, and writing it as 1 leaves the flag unchanged. A match in the same clock as a clearing write wins.
- R12: irq_n is low exactly one clock after both the alarm flag and the interrupt enable are set, and high otherwise.
- R13: Writes to indexes that the current bank does not map (alarm 0x9 to 0xD, timer 0x0 to 0xD, all of bank 3) change nothing, and reads of them return 0. Timer bank index 0xE stores bit 0 as an enable, and its flag bit always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-clock pulse per second |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register index |
| bus_wdata | input | BUS_W | Write data, low nibble used |
| bus_rdata | output | BUS_W | Registered read data |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
A wrong carry or month-length decision inside the digit counters stays hidden until a tick crosses that boundary. It then shows as a wrong digit one read later, so the bench loads the last and second-to-last day of every month across leap, non-leap and century years and compares a full snapshot after one tick. A stale busy counter shows as a busy bit that stays high, or a digit that changes inside the window, within BUSY_CYC clocks of a tick. A corrupted alarm flag or enable shows on irq_n two clocks after the advance that should or should not have matched.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NIB_W    = 4;
  localparam int IDX_W    = 4;
  localparam int N_TIME   = 15;
  localparam int N_ALARM  = 9;
  localparam int CTRL_IDX = 15;
  localparam int FLAG_IDX = 14;
  localparam int DC_BIT   = 3;

  localparam int I_SU = 0, I_ST = 1, I_MU = 2, I_MT = 3, I_HU = 4, I_HT = 5;
  localparam int I_DW = 6, I_DU = 7, I_DT = 8, I_OU = 9, I_OT = 10;
  localparam int I_Y0 = 11, I_Y1 = 12, I_Y2 = 13, I_Y3 = 14;

  typedef logic [NIB_W-1:0] nib_t;
  typedef enum logic [1:0] {BK_TIME = 2'd0, BK_ALARM = 2'd1, BK_TIMER = 2'd2, BK_NONE = 2'd3} bank_e;

  // two-digit decimal value divisible by four
  function automatic logic by4(nib_t t, nib_t u);
    if ((t & 4'h1) != 4'h0) return (u == 4'd2) || (u == 4'd6);
    return (u == 4'd0) || (u == 4'd4) || (u == 4'd8);
  endfunction

  function automatic logic leap(nib_t y3, nib_t y2, nib_t y1, nib_t y0);
    if (y1 == 4'd0 && y0 == 4'd0) return by4(y3, y2);
    return by4(y1, y0);
  endfunction

  function automatic logic [7:0] mdays(logic [7:0] mo, logic lp);
    case (mo)
      8'h02: return lp ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

  // units index of the two-digit alarm fields: sec, min, hour, day
  function automatic int pair_unit(int f);
    return (f < 3) ? 2 * f : I_DU;
  endfunction
endpackage

// File: rtl/rtc_tick_seq.sv
module rtc_tick_seq #(
  parameter int BUSY_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic stop,
  output logic busy,
  output logic adv
);
  localparam int CW = $clog2(BUSY_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (cnt == '0) begin
      if (tick && !stop) cnt <= CW'(BUSY_CYC);
    end else cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);
  assign adv  = (cnt == CW'(1)) && !stop;

  p_window_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(BUSY_CYC));
  p_adv_closes_r4: assert property (@(posedge clk) disable iff (rst)
    adv |=> !busy);
  p_stop_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (stop && !busy) |=> !busy);
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  nib_t wr_data,
  output logic [N_TIME-1:0][NIB_W-1:0] tm_o
);
  logic [N_TIME-1:0][NIB_W-1:0] tm_q, nx;
  logic c_mi, c_hr, c_dy, c_mo, c_yr, cy, lp;
  logic [7:0] last;

  always_comb begin
    nx   = tm_q;
    c_mi = 1'b0; c_hr = 1'b0; c_dy = 1'b0; c_mo = 1'b0; c_yr = 1'b0;
    cy   = 1'b0;
    lp   = leap(tm_q[I_Y3], tm_q[I_Y2], tm_q[I_Y1], tm_q[I_Y0]);
    last = mdays({tm_q[I_OT], tm_q[I_OU]}, lp);
    // seconds
    if (tm_q[I_SU] >= 4'd9) begin
      nx[I_SU] = '0;
      if (tm_q[I_ST] >= 4'd5) begin nx[I_ST] = '0; c_mi = 1'b1; end
      else nx[I_ST] = tm_q[I_ST] + 4'd1;
    end else nx[I_SU] = tm_q[I_SU] + 4'd1;
    // minutes
    if (c_mi) begin
      if (tm_q[I_MU] >= 4'd9) begin
        nx[I_MU] = '0;
        if (tm_q[I_MT] >= 4'd5) begin nx[I_MT] = '0; c_hr = 1'b1; end
        else nx[I_MT] = tm_q[I_MT] + 4'd1;
      end else nx[I_MU] = tm_q[I_MU] + 4'd1;
    end
    // hours
    if (c_hr) begin
      if (tm_q[I_HT] >= 4'd2 && tm_q[I_HU] >= 4'd3) begin
        nx[I_HU] = '0; nx[I_HT] = '0; c_dy = 1'b1;
      end else if (tm_q[I_HU] >= 4'd9) begin
        nx[I_HU] = '0; nx[I_HT] = tm_q[I_HT] + 4'd1;
      end else nx[I_HU] = tm_q[I_HU] + 4'd1;
    end
    // weekday and day of month
    if (c_dy) begin
      nx[I_DW] = (tm_q[I_DW] >= 4'd6) ? 4'd0 : tm_q[I_DW] + 4'd1;
      if ({tm_q[I_DT], tm_q[I_DU]} >= last) begin
        nx[I_DU] = 4'd1; nx[I_DT] = 4'd0; c_mo = 1'b1;
      end else if (tm_q[I_DU] >= 4'd9) begin
        nx[I_DU] = '0; nx[I_DT] = tm_q[I_DT] + 4'd1;
      end else nx[I_DU] = tm_q[I_DU] + 4'd1;
    end
    // month
    if (c_mo) begin
      if ({tm_q[I_OT], tm_q[I_OU]} >= 8'h12) begin
        nx[I_OU] = 4'd1; nx[I_OT] = 4'd0; c_yr = 1'b1;
      end else if (tm_q[I_OU] >= 4'd9) begin
        nx[I_OU] = '0; nx[I_OT] = tm_q[I_OT] + 4'd1;
      end else nx[I_OU] = tm_q[I_OU] + 4'd1;
    end
    // four year digits, ripple
    cy = c_yr;
    for (int k = I_Y0; k <= I_Y3; k++) begin
      if (cy) begin
        if (tm_q[k] >= 4'd9) nx[k] = '0;
        else begin nx[k] = tm_q[k] + 4'd1; cy = 1'b0; end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tm_q       <= '0;
      tm_q[I_DU] <= 4'd1;
      tm_q[I_OU] <= 4'd1;
      tm_q[I_Y3] <= 4'd2;
    end else if (wr_en) tm_q[wr_idx] <= wr_data;
    else if (adv) tm_q <= nx;
  end

  assign tm_o = tm_q;

  p_sec_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (adv && !wr_en && tm_q[I_SU] == 4'd9 && tm_q[I_ST] == 4'd5)
      |=> (tm_q[I_SU] == 4'd0 && tm_q[I_ST] == 4'd0));
  p_dow_range_r7: assert property (@(posedge clk) disable iff (rst)
    (adv && !wr_en && tm_q[I_DW] <= 4'd6) |=> tm_q[I_DW] <= 4'd6);
  p_feb_leap_r8: assert property (@(posedge clk) disable iff (rst)
    (adv && !wr_en && c_dy && lp && {tm_q[I_OT], tm_q[I_OU]} == 8'h02
      && {tm_q[I_DT], tm_q[I_DU]} == 8'h28) |=> {tm_q[I_DT], tm_q[I_DU]} == 8'h29);
  p_year_step_r9: assert property (@(posedge clk) disable iff (rst)
    (adv && !wr_en && c_yr) |=> {tm_q[I_OT], tm_q[I_OU]} == 8'h01);
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic wr_en,
  input  logic ctl_wr,
  input  logic [IDX_W-1:0] wr_idx,
  input  nib_t wr_data,
  input  logic [N_ALARM-1:0][NIB_W-1:0] tm,
  output logic [N_ALARM-1:0][NIB_W-1:0] al_o,
  output logic aie_o,
  output logic af_o,
  output logic irq_n
);
  localparam int N_FLD = 5;

  logic [N_ALARM-1:0][NIB_W-1:0] al_q;
  logic [N_FLD-1:0] fm;
  logic upd_q, aie_q, af_q, hit;

  for (genvar f = 0; f < N_FLD - 1; f++) begin : g_pair
    localparam int U = pair_unit(f);
    assign fm[f] = al_q[U+1][DC_BIT] |
                   ((al_q[U] == tm[U]) && ((al_q[U+1] & 4'h7) == (tm[U+1] & 4'h7)));
  end
  assign fm[N_FLD-1] = al_q[I_DW][DC_BIT] | ((al_q[I_DW] & 4'h7) == (tm[I_DW] & 4'h7));
  assign hit = &fm;

  always_ff @(posedge clk) begin
    if (rst) begin
      al_q  <= '0;
      upd_q <= 1'b0;
      aie_q <= 1'b0;
      af_q  <= 1'b0;
      irq_n <= 1'b1;
    end else begin
      upd_q <= adv;
      if (wr_en) al_q[wr_idx] <= wr_data;
      if (ctl_wr) aie_q <= wr_data[0];
      if (upd_q && hit) af_q <= 1'b1;
      else if (ctl_wr && !wr_data[1]) af_q <= 1'b0;
      irq_n <= ~(af_q & aie_q);
    end
  end

  assign al_o  = al_q;
  assign aie_o = aie_q;
  assign af_o  = af_q;

  p_match_sets_r10: assert property (@(posedge clk) disable iff (rst)
    (upd_q && hit) |=> af_q);
  p_flag_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (af_q && !(ctl_wr && !wr_data[1])) |=> af_q);
  p_irq_low_r12: assert property (@(posedge clk) disable iff (rst)
    (af_q && aie_q) |=> !irq_n);
  p_irq_high_r12: assert property (@(posedge clk) disable iff (rst)
    !(af_q && aie_q) |=> irq_n);
endmodule

// File: rtl/nibble_rtc.sv
module nibble_rtc
  import rtc_pkg::*;
#(
  parameter int BUS_W    = 8,
  parameter int BUSY_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_1hz,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [3:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             irq_n
);
  logic [N_TIME-1:0][NIB_W-1:0]  tm;
  logic [N_ALARM-1:0][NIB_W-1:0] al;
  bank_e bank_q;
  logic  stop_q, tie_q, busy, adv, aie, af;
  logic  wr, is_ctl, t_we, a_we, ac_we, tc_we;
  logic  unused_wd;
  nib_t  wd, rd_nib;

  assign wd        = bus_wdata[NIB_W-1:0];
  assign unused_wd = ^bus_wdata;
  assign wr        = bus_sel && bus_we;
  assign is_ctl    = (bus_addr == IDX_W'(CTRL_IDX));
  assign t_we      = wr && !is_ctl && bank_q == BK_TIME;
  assign a_we      = wr && bank_q == BK_ALARM && bus_addr <= IDX_W'(N_ALARM - 1);
  assign ac_we     = wr && bank_q == BK_ALARM && bus_addr == IDX_W'(FLAG_IDX);
  assign tc_we     = wr && bank_q == BK_TIMER && bus_addr == IDX_W'(FLAG_IDX);

  rtc_tick_seq #(.BUSY_CYC(BUSY_CYC)) u_seq (
    .clk(clk), .rst(rst), .tick(tick_1hz), .stop(stop_q), .busy(busy), .adv(adv)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst(rst), .adv(adv), .wr_en(t_we), .wr_idx(bus_addr),
    .wr_data(wd), .tm_o(tm)
  );

  rtc_alarm u_alm (
    .clk(clk), .rst(rst), .adv(adv), .wr_en(a_we), .ctl_wr(ac_we),
    .wr_idx(bus_addr), .wr_data(wd), .tm(tm[N_ALARM-1:0]), .al_o(al),
    .aie_o(aie), .af_o(af), .irq_n(irq_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= BK_TIME;
      stop_q <= 1'b0;
      tie_q  <= 1'b0;
    end else begin
      if (wr && is_ctl) begin
        bank_q <= bank_e'(wd[3:2]);
        stop_q <= wd[1];
      end
      if (tc_we) tie_q <= wd[0];
    end
  end

  always_comb begin
    rd_nib = '0;
    if (is_ctl) rd_nib = {bank_q, stop_q, busy};
    else begin
      case (bank_q)
        BK_TIME:  rd_nib = tm[bus_addr];
        BK_ALARM: begin
          if (bus_addr <= IDX_W'(N_ALARM - 1)) rd_nib = al[bus_addr];
          else if (bus_addr == IDX_W'(FLAG_IDX)) rd_nib = {2'b00, af, aie};
        end
        BK_TIMER: if (bus_addr == IDX_W'(FLAG_IDX)) rd_nib = {3'b000, tie_q};
        default:  rd_nib = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_sel && !bus_we) bus_rdata <= BUS_W'(rd_nib);
    else bus_rdata <= '0;
  end

  p_bank_load_r3: assert property (@(posedge clk) disable iff (rst)
    (wr && is_ctl) |=> bank_q == $past(bank_e'(wd[3:2])));
  p_idle_read_r2: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_we) |=> bus_rdata == '0);
  p_empty_bank_r13: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_we && !is_ctl && bank_q == BK_NONE) |=> bus_rdata == '0);
endmodule

// File: tb/sim_nibble_rtc.sv
module sim_nibble_rtc;
  localparam int BW   = 8;
  localparam int BUSY = 4;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, sel = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [BW-1:0] wdat = '0;
  logic [BW-1:0] rdat;
  logic irqn;
  logic [BW-1:0] d;
  logic [59:0] got;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nibble_rtc #(.BUS_W(BW), .BUSY_CYC(BUSY)) u0 (
    .clk(clk), .rst(rst), .tick_1hz(tick), .bus_sel(sel), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdat), .bus_rdata(rdat), .irq_n(irqn)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [3:0] a, input logic [BW-1:0] v);
    sel = 1'b1; we = 1'b1; addr = a; wdat = v;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [BW-1:0] v);
    sel = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    v = rdat; sel = 1'b0;
  endtask

  task automatic ctl(input logic [1:0] bank, input logic stp);
    wr(4'hF, BW'({bank, stp, 1'b0}));
  endtask

  task automatic pulse();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic tick_wait();
    pulse();
    repeat (BUSY + 4) @(negedge clk);
  endtask

  function automatic logic [59:0] enc(int y, int mo, int dd, int dw, int h, int mi, int s);
    logic [59:0] v;
    v[3:0]   = 4'(s % 10);        v[7:4]   = 4'(s / 10);
    v[11:8]  = 4'(mi % 10);       v[15:12] = 4'(mi / 10);
    v[19:16] = 4'(h % 10);        v[23:20] = 4'(h / 10);
    v[27:24] = 4'(dw);
    v[31:28] = 4'(dd % 10);       v[35:32] = 4'(dd / 10);
    v[39:36] = 4'(mo % 10);       v[43:40] = 4'(mo / 10);
    v[47:44] = 4'(y % 10);        v[51:48] = 4'((y / 10) % 10);
    v[55:52] = 4'((y / 100) % 10); v[59:56] = 4'(y / 1000);
    return v;
  endfunction

  function automatic bit is_leap(int y);
    return ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
  endfunction

  function automatic int mlen(int y, int mo);
    case (mo)
      2: return is_leap(y) ? 29 : 28;
      4, 6, 9, 11: return 30;
      default: return 31;
    endcase
  endfunction

  task automatic set_time(int y, int mo, int dd, int dw, int h, int mi, int s);
    logic [59:0] v;
    v = enc(y, mo, dd, dw, h, mi, s);
    ctl(2'd0, 1'b1);
    for (int i = 0; i < 15; i++) wr(4'(i), BW'(v[4*i +: 4]));
    ctl(2'd0, 1'b0);
  endtask

  task automatic read_time(output logic [59:0] v);
    logic [BW-1:0] t;
    for (int i = 0; i < 15; i++) begin
      rd(4'(i), t);
      v[4*i +: 4] = t[3:0];
    end
  endtask

  task automatic run_case(input string tag, int y, int mo, int dd, int dw, int h, int mi, int s);
    logic [59:0] v;
    set_time(y, mo, dd, dw, h, mi, s);
    tick_wait();
    read_time(v);
    s++;
    if (s == 60) begin
      s = 0; mi++;
      if (mi == 60) begin
        mi = 0; h++;
        if (h == 24) begin
          h = 0; dw = (dw + 1) % 7; dd++;
          if (dd > mlen(y, mo)) begin
            dd = 1; mo++;
            if (mo == 13) begin mo = 1; y = (y + 1) % 10000; end
          end
        end
      end
    end
    chk(tag, 64'(v), 64'(enc(y, mo, dd, dw, h, mi, s)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int ys[9] = '{1999, 2000, 2023, 2024, 1900, 2100, 2400, 9999, 2096};
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    read_time(got);
    chk("R1 reset time", 64'(got), 64'(enc(2000, 1, 1, 0, 0, 0, 0)));
    rd(4'hF, d);
    chk("R1 reset control", 64'(d), 64'h0);
    chk("R1 reset irq_n", 64'(irqn), 64'h1);
    ctl(2'd1, 1'b0);
    rd(4'hE, d);
    chk("R1 reset alarm control", 64'(d), 64'h0);

    // R3 control nibble from several banks
    ctl(2'd2, 1'b0);
    rd(4'hF, d);
    chk("R3 control in timer bank", 64'(d), 64'h08);
    ctl(2'd1, 1'b1);
    rd(4'hF, d);
    chk("R3 control with stop in alarm bank", 64'(d), 64'h06);
    wr(4'hF, BW'(8'h01));
    rd(4'hF, d);
    chk("R3 busy bit not writable", 64'(d), 64'h00);

    // R2 upper write bits dropped, upper read bits zero
    ctl(2'd0, 1'b1);
    wr(4'h0, BW'(8'hF7));
    rd(4'h0, d);
    chk("R2 low nibble only", 64'(d), 64'h07);
    rd(4'hE, d);
    chk("R2 year thousands full width", 64'(d), 64'h02);

    // R4 busy window
    set_time(2024, 5, 10, 3, 10, 20, 30);
    pulse();
    rd(4'hF, d);
    chk("R4 busy raised", 64'(d), 64'h01);
    rd(4'h0, d);
    chk("R4 digit held during busy", 64'(d), 64'h00);
    repeat (BUSY + 3) @(negedge clk);
    rd(4'h0, d);
    chk("R4 digit advanced after busy", 64'(d), 64'h01);
    rd(4'hF, d);
    chk("R4 busy cleared", 64'(d), 64'h00);

    // R5 stop freezes counting
    ctl(2'd0, 1'b1);
    pulse();
    rd(4'hF, d);
    chk("R5 no busy while stopped", 64'(d), 64'h02);
    repeat (BUSY + 3) @(negedge clk);
    rd(4'h0, d);
    chk("R5 digit frozen while stopped", 64'(d), 64'h01);
    ctl(2'd0, 1'b0);

    // R6 and R7 small carries
    run_case("R6 seconds step", 2024, 5, 10, 3, 12, 34, 58);
    run_case("R6 seconds wrap", 2024, 5, 10, 3, 12, 34, 59);
    run_case("R6 minutes wrap", 2024, 5, 10, 3, 12, 59, 59);
    run_case("R6 hour units wrap", 2024, 5, 10, 3, 9, 59, 59);
    run_case("R6 hour 19 to 20", 2024, 5, 10, 3, 19, 59, 59);
    run_case("R7 midnight weekday wrap", 2024, 5, 10, 6, 23, 59, 59);
    run_case("R7 day units carry", 2024, 5, 19, 2, 23, 59, 59);

    // R7 R8 R9 sweep: last two days of every month across year kinds
    foreach (ys[k]) begin
      for (int mo = 1; mo <= 12; mo++) begin
        for (int back = 1; back >= 0; back--) begin
          int dd;
          dd = mlen(ys[k], mo) - back;
          if (mo == 2) run_case("R8 february end", ys[k], mo, dd, (ys[k] + mo) % 7, 23, 59, 59);
          else if (mo == 12 && back == 0) run_case("R9 year end", ys[k], mo, dd, (ys[k] + mo) % 7, 23, 59, 59);
          else run_case("R7 month end", ys[k], mo, dd, (ys[k] + mo) % 7, 23, 59, 59);
        end
      end
    end

    // R10 alarm on seconds only
    ctl(2'd1, 1'b0);
    wr(4'h0, BW'(8'h05)); wr(4'h1, BW'(8'h00));
    wr(4'h2, BW'(8'h00)); wr(4'h3, BW'(8'h08));
    wr(4'h4, BW'(8'h00)); wr(4'h5, BW'(8'h08));
    wr(4'h6, BW'(8'h08)); wr(4'h7, BW'(8'h00));
    wr(4'h8, BW'(8'h08));
    wr(4'hE, BW'(8'h01));
    rd(4'h3, d);
    chk("R10 alarm digit readback", 64'(d), 64'h08);
    set_time(2024, 5, 10, 3, 12, 29, 3);
    tick_wait();
    ctl(2'd1, 1'b0);
    rd(4'hE, d);
    chk("R10 no match at 04", 64'(d), 64'h01);
    chk("R12 irq_n high without flag", 64'(irqn), 64'h1);
    tick_wait();
    rd(4'hE, d);
    chk("R10 match at 05", 64'(d), 64'h03);
    chk("R12 irq_n low with flag and enable", 64'(irqn), 64'h0);
    wr(4'hE, BW'(8'h03));
    rd(4'hE, d);
    chk("R11 writing one keeps flag", 64'(d), 64'h03);
    wr(4'hE, BW'(8'h01));
    rd(4'hE, d);
    chk("R11 writing zero clears flag", 64'(d), 64'h01);
    chk("R12 irq_n released", 64'(irqn), 64'h1);

    // R10 a compared field that differs blocks the match
    wr(4'h2, BW'(8'h00)); wr(4'h3, BW'(8'h03));
    set_time(2024, 5, 10, 3, 12, 29, 4);
    tick_wait();
    ctl(2'd1, 1'b0);
    rd(4'hE, d);
    chk("R10 minutes mismatch blocks", 64'(d), 64'h01);
    set_time(2024, 5, 10, 3, 12, 30, 4);
    tick_wait();
    ctl(2'd1, 1'b0);
    rd(4'hE, d);
    chk("R10 seconds and minutes match", 64'(d), 64'h03);

    // R11 R12 flag without enable
    wr(4'hE, BW'(8'h00));
    set_time(2024, 5, 10, 3, 12, 30, 4);
    tick_wait();
    ctl(2'd1, 1'b0);
    rd(4'hE, d);
    chk("R11 flag sets with enable off", 64'(d), 64'h02);
    chk("R12 irq_n high with enable off", 64'(irqn), 64'h1);

    // R13 unmapped indexes and timer control
    wr(4'h9, BW'(8'h0F));
    rd(4'h9, d);
    chk("R13 alarm index 9 unmapped", 64'(d), 64'h00);
    ctl(2'd3, 1'b0);
    wr(4'h0, BW'(8'h09));
    rd(4'h0, d);
    chk("R13 bank 3 reads zero", 64'(d), 64'h00);
    ctl(2'd0, 1'b0);
    rd(4'h0, d);
    chk("R13 bank 3 write left seconds", 64'(d), 64'h05);
    ctl(2'd2, 1'b0);
    wr(4'h3, BW'(8'h07));
    rd(4'h3, d);
    chk("R13 timer bank low index", 64'(d), 64'h00);
    wr(4'hE, BW'(8'h03));
    rd(4'hE, d);
    chk("R13 timer enable stored, flag zero", 64'(d), 64'h01);
    wr(4'hE, BW'(8'h00));
    rd(4'hE, d);
    chk("R13 timer control cleared", 64'(d), 64'h00);
    ctl(2'd0, 1'b0);
    rd(4'h3, d);
    chk("R13 timer bank write left minutes", 64'(d), 64'h03);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule